// File: doc/BRIEF.md
# Timestamp Width Extender

This block turns a truncated hardware time capture into a full 64-bit nanosecond timestamp. A capture records only the low 32 bits of the clock's nanosecond count. The block places that capture on the full time line by comparing it with a cached 64-bit copy of the clock, which is refreshed elsewhere. The capture word can arrive in one of two layouts. In the short layout it is a bare 32-bit nanosecond value. In the raw layout it is a 40-bit word that carries the nanoseconds in bits 39:8 and a valid flag in bit 0.

The block takes the difference between the capture and the low 32 bits of the cached time, modulo 2^32. If that difference lies in the lower half of the 32-bit range, the capture is newer than the cached time and the difference is added. Otherwise the capture is older, and the distance back is subtracted. A capture taken a little before the last cache refresh therefore lands just before the cached time instead of wrapping about four seconds forward. The result is registered and appears one clock after an accepted input.

The true distance between the capture and the cached time must stay well below 2^31 ns, about 2.1 s. A refresh interval of 500 ms or less gives that margin.

Top module: `ts_extender`

## Requirements
- R1: When (capture − cached[31:0]) mod 2^32 is at most 0x7FFFFFFF, the result is cached + that difference.
- R2: When that difference exceeds 0x7FFFFFFF, the result is cached − ((cached[31:0] − capture) mod 2^32).
- R3: A difference of exactly 0x7FFFFFFF extends forward, and a difference of exactly 0x80000000 extends backward by 2^31.
- R4: With `fmt_raw` = 1 the nanosecond value is taken from bits 39:8 of `cap_word`.
- R5: With `fmt_raw` = 1, an input whose bit 0 is 0 is rejected: `ts_valid` stays low and `ts_out` keeps its previous value.
- R6: `ts_valid` is high exactly in the clock after an accepted input (`cap_valid` high, and bit 0 set when `fmt_raw` = 1), and low otherwise.
- R7: `ts_out` holds its value until the next accepted input.
- R8: All 64-bit arithmetic wraps modulo 2^64, without saturation, in both directions.
- R9: While `rst` is high, `ts_valid` is 0 and `ts_out` is 0.
- R10: With `fmt_raw` = 0 the nanosecond value is `cap_word[31:0]`, bits 39:32 are ignored, and no flag is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cached_time | input | 64 | Cached full clock time in ns |
| cap_word | input | 40 | Capture word, short or raw layout |
| fmt_raw | input | 1 | 0: short 32-bit layout, 1: raw 40-bit layout |
| cap_valid | input | 1 | Input strobe |
| ts_out | output | 64 | Extended timestamp |
| ts_valid | output | 1 | High one clock after an accepted input |

## Verification
The bench drives captures that sit a little after and a little before the cached time. This separates forward extension from backward extension. It also drives differences of exactly 0x7FFFFFFF and 0x80000000, which locate the half-range threshold to the last count. Cached values near 2^64 and near zero show that the sum and the difference wrap rather than saturate. Raw words with and without the flag bit, short words with junk in the upper byte, and idle cycles show which inputs are accepted and that the held result does not change.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;
  typedef enum logic {
    FMT_SHORT = 1'b0,
    FMT_RAW   = 1'b1
  } ts_fmt_e;
endpackage

// File: rtl/ts_ext_field_sel.sv
module ts_ext_field_sel
  import ts_ext_pkg::*;
#(
  parameter int RAW_W   = 40,
  parameter int SHORT_W = 32,
  parameter int SHIFT   = 8
) (
  input  logic [RAW_W-1:0]   raw_word,
  input  ts_fmt_e            fmt,
  input  logic               strobe,
  output logic [SHORT_W-1:0] ns_low,
  output logic               accept
);
  logic [SHORT_W-1:0] raw_ns;

  // Raw layout: the nanoseconds sit above the flag byte.
  generate
    if (SHIFT + SHORT_W <= RAW_W) begin : g_raw_fit
      assign raw_ns = raw_word[SHIFT +: SHORT_W];
    end else begin : g_raw_short
      assign raw_ns = SHORT_W'(raw_word >> SHIFT);
    end
  endgenerate

  always_comb begin
    if (fmt == FMT_RAW) begin
      ns_low = raw_ns;
      accept = strobe && raw_word[0];
    end else begin
      ns_low = raw_word[SHORT_W-1:0];
      accept = strobe;
    end
  end

  // R5: a raw word without its flag is never accepted.
  always_comb begin
    a_r5_flag_gate: assert (!(accept && fmt == FMT_RAW && !raw_word[0]))
      else $error("R5 raw word accepted without flag");
  end
endmodule

// File: rtl/ts_ext_core.sv
module ts_ext_core #(
  parameter int TIME_W  = 64,
  parameter int SHORT_W = 32
) (
  input  logic [TIME_W-1:0]  ref_time,
  input  logic [SHORT_W-1:0] ns_low,
  output logic [TIME_W-1:0]  full_time,
  output logic               went_back
);
  localparam int PAD_W = TIME_W - SHORT_W;
  localparam logic [TIME_W-1:0] HALF_SPAN = TIME_W'(1) << (SHORT_W - 1);

  logic [SHORT_W-1:0] ref_low;
  logic [SHORT_W-1:0] fwd_gap;
  logic [SHORT_W-1:0] back_gap;
  logic [TIME_W-1:0]  fwd_sum;
  logic [TIME_W-1:0]  back_sum;

  assign ref_low  = ref_time[SHORT_W-1:0];
  assign fwd_gap  = ns_low - ref_low;
  assign back_gap = ref_low - ns_low;
  // Top bit set means the gap exceeds the half range.
  assign went_back = fwd_gap[SHORT_W-1];
  assign fwd_sum   = ref_time + {{PAD_W{1'b0}}, fwd_gap};
  assign back_sum  = ref_time - {{PAD_W{1'b0}}, back_gap};
  assign full_time = went_back ? back_sum : fwd_sum;

  logic [TIME_W-1:0] dist_fwd;
  logic [TIME_W-1:0] dist_back;
  assign dist_fwd  = full_time - ref_time;
  assign dist_back = ref_time - full_time;

  // R1/R2: the result never lies more than half the short range away.
  always_comb begin
    a_r1_fwd_bound: assert (went_back || dist_fwd < HALF_SPAN)
      else $error("R1 forward result out of range");
    a_r2_back_bound: assert (!went_back || (dist_back <= HALF_SPAN && dist_back != '0))
      else $error("R2 backward result out of range");
  end
endmodule

// File: rtl/ts_extender.sv
module ts_extender
  import ts_ext_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int SHORT_W = 32,
  parameter int RAW_W   = 40,
  parameter int SHIFT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] cached_time,
  input  logic [RAW_W-1:0]  cap_word,
  input  logic              fmt_raw,
  input  logic              cap_valid,
  output logic [TIME_W-1:0] ts_out,
  output logic              ts_valid
);
  logic [SHORT_W-1:0] ns_low;
  logic               accept;
  logic [TIME_W-1:0]  full_time;
  logic               went_back;
  ts_fmt_e            fmt;

  assign fmt = ts_fmt_e'(fmt_raw);

  ts_ext_field_sel #(.RAW_W(RAW_W), .SHORT_W(SHORT_W), .SHIFT(SHIFT)) u_sel (
    .raw_word (cap_word),
    .fmt      (fmt),
    .strobe   (cap_valid),
    .ns_low   (ns_low),
    .accept   (accept)
  );

  ts_ext_core #(.TIME_W(TIME_W), .SHORT_W(SHORT_W)) u_core (
    .ref_time  (cached_time),
    .ns_low    (ns_low),
    .full_time (full_time),
    .went_back (went_back)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_out   <= '0;
      ts_valid <= 1'b0;
    end else begin
      ts_valid <= accept;
      if (accept) ts_out <= full_time;
    end
  end

  // R6: an accepted port-level input yields a valid output next clock.
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && (!fmt_raw || cap_word[0])) |=> ts_valid);
  // R6: no strobe, no output.
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cap_valid |=> !ts_valid);
  // R5: a raw word without its flag produces nothing.
  a_r5_noflag_silent: assert property (@(posedge clk) disable iff (rst)
    (fmt_raw && !cap_word[0]) |=> !ts_valid);
  // R7: the result only changes when a new one is delivered.
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !ts_valid |-> $stable(ts_out));
  // R9: the reset state.
  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!ts_valid && ts_out == '0));
endmodule

// File: tb/ts_extender_tb.sv
module ts_extender_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cached_time = '0;
  logic [39:0] cap_word = '0;
  logic        fmt_raw = 1'b0;
  logic        cap_valid = 1'b0;
  logic [63:0] ts_out;
  logic        ts_valid;

  int errors = 0;
  int checks = 0;
  longint unsigned exp_ts = 0;
  logic exp_v = 1'b0;

  always #5 clk = ~clk;

  ts_extender u_dut (
    .clk(clk), .rst(rst), .cached_time(cached_time), .cap_word(cap_word),
    .fmt_raw(fmt_raw), .cap_valid(cap_valid), .ts_out(ts_out), .ts_valid(ts_valid)
  );

  // Reference: signed 32-bit distance added to the cached time.
  function automatic longint unsigned model(longint unsigned c, logic [31:0] cap);
    logic [31:0] raw_d;
    int d;
    raw_d = cap - c[31:0];
    d = int'(raw_d);
    return c + longint'(d);
  endfunction

  task automatic step(input longint unsigned c, input logic [39:0] w,
                      input logic f, input logic v, input string tag);
    logic [31:0] ns;
    logic ok;
    @(negedge clk);
    cached_time = c;
    cap_word = w;
    fmt_raw = f;
    cap_valid = v;
    ns = f ? w[39:8] : w[31:0];
    ok = v && (!f || w[0]);
    exp_v = ok;
    if (ok) exp_ts = model(c, ns);
    @(posedge clk);
    #1;
    checks++;
    if (ts_valid !== exp_v) begin
      errors++;
      $display("FAIL %s valid: actual=%0b expected=%0b", tag, ts_valid, exp_v);
    end
    checks++;
    if (ts_out !== exp_ts) begin
      errors++;
      $display("FAIL %s ts: actual=%h expected=%h", tag, ts_out, exp_ts);
    end
  endtask

  function automatic logic [39:0] rawfmt(logic [31:0] ns, logic flag);
    return {ns, 7'h35, flag};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    checks++;
    if (ts_valid !== 1'b0 || ts_out !== 64'h0) begin
      errors++;
      $display("FAIL R9 reset: actual=%0b/%h expected=0/0", ts_valid, ts_out);
    end
    @(negedge clk);
    rst = 1'b0;
    step(64'h0000_0012_3456_0000, 40'h00_3456_1000, 1'b0, 1'b1, "R1 forward");
    step(64'h0000_0012_3456_0000, 40'h00_3455_FB00, 1'b0, 1'b1, "R2 backward");
    step(64'h0000_0012_3456_0000, 40'h00_3456_0000, 1'b0, 1'b1, "R1 equal");
    step(64'h0000_0040_0000_0000, 40'h00_7FFF_FFFF, 1'b0, 1'b1, "R3 edge forward");
    step(64'h0000_0040_0000_0000, 40'h00_8000_0000, 1'b0, 1'b1, "R3 edge backward");
    step(64'h0000_0001_8000_0010, 40'h00_0000_0005, 1'b0, 1'b1, "R1 cross low wrap");
    step(64'h0000_0002_0000_0010, 40'h00_FFFF_FFF0, 1'b0, 1'b1, "R2 borrow high");
    step(64'h0000_0012_3456_0000, 40'hA5_3456_2000, 1'b0, 1'b1, "R10 upper ignored");
    step(64'h0000_0012_3456_0000, rawfmt(32'h3456_0100, 1'b1), 1'b1, 1'b1, "R4 raw forward");
    step(64'h0000_0012_3456_0000, rawfmt(32'h3455_0000, 1'b1), 1'b1, 1'b1, "R4 raw backward");
    step(64'h0000_0099_0000_0000, rawfmt(32'h0000_0777, 1'b0), 1'b1, 1'b1, "R5 no flag");
    step(64'h0000_0099_0000_0000, rawfmt(32'h0000_0777, 1'b1), 1'b1, 1'b0, "R7 idle hold");
    step(64'h0000_0055_0000_0000, 40'h00_0000_1234, 1'b0, 1'b0, "R6 idle quiet");
    step(64'hFFFF_FFFF_FFFF_FFF0, 40'h00_0000_0010, 1'b0, 1'b1, "R8 wrap up");
    step(64'h0000_0000_0000_0010, 40'h00_FFFF_FFF0, 1'b0, 1'b1, "R8 wrap down");
    step(64'h0000_0000_0000_0010, 40'h00_0000_0020, 1'b0, 1'b0, "R7 hold after wrap");
    for (int i = 0; i < 40; i++) begin
      longint unsigned c;
      logic [31:0] n;
      c = {32'(i * 977 + 3), 32'(i * 32'h0DEF_1234)};
      n = c[31:0] + 32'(i * 32'h0600_0001);
      step(c, (i % 3 == 0) ? rawfmt(n, 1'(i % 2)) : {8'(i), n},
           1'(i % 3 == 0), 1'(i % 5 != 4), "R6 sweep");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule